// File: doc/BRIEF.md
# Dual-Clock 36-Bit FIFO with Selectable Flag Timing

This block is a first-in first-out buffer for 36-bit words. The write port and the read port run on clocks that need not be related. Each side keeps its own binary pointer and passes a Gray-coded copy of it to the other side through a two-stage synchronizer. Each side works out its flags from its own pointer and the synchronized copy of the other. The storage is a register array that the write clock writes and the read pointer addresses.

A master reset takes a snapshot of the configuration inputs. These choose the flag timing, the default almost-empty and almost-full offset, and whether the offsets are later reprogrammed serially or in parallel. In standard timing the read side reports empty, the write side reports full, and a read strobe is needed before a word reaches the output. In fall-through timing the read side reports output-ready, the write side reports input-ready, and the head word is presented with no read request. A soft reset empties the buffer and leaves the configuration alone. A rewind pulse sends the read pointer back to the first word written since the last reset, so the data already read can be read again.

Top module: `dualclk_fifo36`

## Requirements
- R1: While `hard_rst` or `soft_rst` is held, and after it is released, the buffer is empty. In standard mode `rd_flag`=1 (empty) and `wr_flag`=0 (not full). In fall-through mode `rd_flag`=0 (no word) and `wr_flag`=1 (room). In both modes `near_empty`=1 and `near_full`=0.
- R2: Words leave in the order they were accepted. In standard mode a read accepted on a `rd_clk` edge (`rd_en`=1 with `rd_flag`=0 before the edge) puts the next word on `rd_data` at that edge.
- R3: When the buffer holds DEPTH words, `wr_flag` shows full (standard: 1) and further writes are dropped: they store nothing and do not advance the write pointer.
- R4: In standard mode a read while empty is dropped: `rd_data` holds its value and the read pointer does not move.
- R5: In fall-through mode, once a word is stored it is loaded onto `rd_data` and `rd_flag` rises without a read. `rd_en` with `rd_flag`=1 consumes that word.
- R6: `near_empty` is 1 exactly when the words held on the read side are no more than the almost-empty offset. In fall-through mode the held count includes the presented word.
- R7: `near_full` is 1 exactly when the free locations seen by the write side are no more than the almost-full offset.
- R8: `ofs_preset` is sampled during `hard_rst` and sets both offsets: 0→8, 1→16, 2→64, 3→256, any other value→1024.
- R9: With `cfg_serial`=0 at master reset, each `ofs_par_ld` pulse takes one value from `ofs_par_val`. The first pulse sets the almost-empty offset, the second sets the almost-full offset, and later pulses are ignored until the next master reset.
- R10: With `cfg_serial`=1 at master reset, each `ofs_ser_ld` pulse takes one `ofs_ser_bit`. The first 11 bits fill the almost-empty offset starting at bit 0, the next 11 fill the almost-full offset the same way, and later bits are ignored.
- R11: `soft_rst` empties the buffer and keeps the flag mode and the offsets.
- R12: A `rewind` pulse on `rd_clk` returns the read pointer to the first word written since the last reset, so those words come out again in order.
- R13: Both ports may run at the same time, and every accepted word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| hard_rst | input | 1 | Master reset, synchronous, active high; clears data and loads configuration |
| soft_rst | input | 1 | Partial reset, synchronous, active high; clears data only |
| ft_mode | input | 1 | Flag timing chosen at master reset: 1 fall-through, 0 standard |
| cfg_serial | input | 1 | Offset loading chosen at master reset: 1 serial, 0 parallel |
| ofs_preset | input | 3 | Default offset select, sampled at master reset |
| ofs_par_ld | input | 1 | Parallel offset load strobe (write clock) |
| ofs_par_val | input | 11 | Parallel offset value |
| ofs_ser_ld | input | 1 | Serial offset bit strobe (write clock) |
| ofs_ser_bit | input | 1 | Serial offset bit |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| near_full | output | 1 | Almost-full flag |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Retransmit pulse (read clock) |
| rd_data | output | 36 | Read word |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| near_empty | output | 1 | Almost-empty flag |

## Verification
Some properties are checked on every cycle. A write into a full buffer must leave the write pointer where it was, and a standard-mode read of an empty buffer must leave the pointer and the output where they were. The write pointer's Gray code may change by at most one bit per cycle. The full flag must imply almost-full, and an empty read side must imply almost-empty. In fall-through mode a stored word must be presented one cycle after the output stage goes free. The offset loader must never step past its last bit, and the configuration must not change outside a master reset. The bench scenarios cover what needs a history of traffic: data order across clock domains, the exact thresholds of both partial flags for each kind of offset source, offsets kept through a soft reset, rewind replaying words, and dropped writes and reads leaving no trace in the data that comes out later.

// File: rtl/fifo36_pkg.sv
package fifo36_pkg;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_FT  = 1'b1
    } flag_mode_e;

    typedef struct packed {
        flag_mode_e mode;
        logic       serial;
    } cfg_t;

    typedef struct packed {
        logic full;
        logic near_full;
    } wr_stat_t;

    typedef struct packed {
        logic empty;
        logic near_empty;
        logic hold;
    } rd_stat_t;

    function automatic int unsigned preset_offset(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 64;
            3'd3:    return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fq_sync.sv
module fq_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fq_cfg.sv
module fq_cfg
    import fifo36_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          hard_rst,
    input  logic          ft_mode,
    input  logic          cfg_serial,
    input  logic [2:0]    ofs_preset,
    input  logic          par_ld,
    input  logic [AW-1:0] par_val,
    input  logic          ser_ld,
    input  logic          ser_bit,
    output cfg_t          cfg,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    localparam int NBITS = 2 * AW;
    localparam int SW    = $clog2(NBITS + 1);
    localparam int IW    = $clog2(AW);

    logic [SW-1:0] step;
    logic [IW-1:0] idx;
    logic          hi_half, par_go, ser_go;

    always_comb begin
        hi_half = step >= SW'(AW);
        idx     = IW'(hi_half ? step - SW'(AW) : step);
        par_go  = !cfg.serial && par_ld && (step < SW'(2));
        ser_go  =  cfg.serial && ser_ld && (step < SW'(NBITS));
    end

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            cfg.mode   <= ft_mode ? MODE_FT : MODE_STD;
            cfg.serial <= cfg_serial;
            ae_off     <= AW'(preset_offset(ofs_preset));
            af_off     <= AW'(preset_offset(ofs_preset));
            step       <= '0;
        end else begin
            if (par_go) begin
                if (step == '0) ae_off <= par_val;
                else            af_off <= par_val;
                step <= step + 1'b1;
            end
            if (ser_go) begin
                if (hi_half) af_off[idx] <= ser_bit;
                else         ae_off[idx] <= ser_bit;
                step <= step + 1'b1;
            end
        end
    end

    assert_step_bound_R10: assert property (@(posedge clk) disable iff (hard_rst)
        step <= SW'(NBITS));

    assert_mode_kept_R11: assert property (@(posedge clk) disable iff (hard_rst)
        $stable(cfg));
endmodule

// File: rtl/fq_wside.sv
module fq_wside
    import fifo36_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ft,
    input  logic [AW-1:0] af_off,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output wr_stat_t      st,
    output logic          wr_flag
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] CAP = PW'(1) << AW;

    logic [PW-1:0] wptr, wnext, rbin, used, room;

    always_comb begin
        rbin         = PW'(gray_to_bin(32'(rgray_s)));
        used         = wptr - rbin;
        room         = CAP - used;
        st.full      = (used == CAP);
        st.near_full = (room <= {1'b0, af_off});
        we           = wr_en && !st.full;
        waddr        = wptr[AW-1:0];
        wnext        = wptr + 1'b1;
        wr_flag      = ft ? !st.full : st.full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st.full && wr_en) |=> $stable(wptr));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        used <= CAP);

    assert_gray_step_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_full_near_R7: assert property (@(posedge clk) disable iff (rst)
        st.full |-> st.near_full);
endmodule

// File: rtl/fq_rside.sv
module fq_rside
    import fifo36_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ft,
    input  logic [AW-1:0] ae_off,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output rd_stat_t      st,
    output logic          rd_flag
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rptr, rnext, wbin, avail, occ;
    logic          ovalid, take_std, fetch, drop, adv;

    always_comb begin
        wbin          = PW'(gray_to_bin(32'(wgray_s)));
        avail         = wbin - rptr;
        st.empty      = (avail == '0);
        st.hold       = ovalid;
        take_std      = !ft && rd_en && !st.empty && !rewind;
        fetch         =  ft && !st.empty && (!ovalid || rd_en) && !rewind;
        drop          =  ft && rd_en && ovalid && st.empty && !rewind;
        adv           = take_std || fetch;
        rnext         = rptr + 1'b1;
        raddr         = rptr[AW-1:0];
        occ           = avail + PW'(ft && ovalid);
        st.near_empty = (occ <= {1'b0, ae_off});
        rd_flag       = ft ? ovalid : st.empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr    <= '0;
            rgray   <= '0;
            ovalid  <= 1'b0;
            rd_data <= '0;
        end else if (rewind) begin
            rptr   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
        end else begin
            if (adv) begin
                rptr    <= rnext;
                rgray   <= rnext ^ (rnext >> 1);
                rd_data <= mem_q;
            end
            if (fetch)     ovalid <= 1'b1;
            else if (drop) ovalid <= 1'b0;
        end
    end

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (!ft && rd_en && st.empty && !rewind) |=> ($stable(rd_data) && $stable(rptr)));

    assert_ft_present_R5: assert property (@(posedge clk) disable iff (rst)
        (ft && !ovalid && !st.empty && !rewind) |=> ovalid);

    assert_empty_near_R6: assert property (@(posedge clk) disable iff (rst)
        (st.empty && !ovalid) |-> st.near_empty);
endmodule

// File: rtl/dualclk_fifo36.sv
module dualclk_fifo36
    import fifo36_pkg::*;
#(
    parameter  int DEPTH  = 2048,
    parameter  int DW     = 36,
    parameter  int STAGES = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          hard_rst,
    input  logic          soft_rst,
    input  logic          ft_mode,
    input  logic          cfg_serial,
    input  logic [2:0]    ofs_preset,
    input  logic          ofs_par_ld,
    input  logic [AW-1:0] ofs_par_val,
    input  logic          ofs_ser_ld,
    input  logic          ofs_ser_bit,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_flag,
    output logic          near_full,
    input  logic          rd_en,
    input  logic          rewind,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          near_empty
);
    localparam int PW = AW + 1;

    cfg_t          cfg;
    wr_stat_t      wst;
    rd_stat_t      rst_s;
    logic [AW-1:0] ae_off, af_off, waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic          we, ft, data_rst;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] mem [DEPTH];

    assign data_rst   = hard_rst || soft_rst;
    assign ft         = (cfg.mode == MODE_FT);
    assign near_full  = wst.near_full;
    assign near_empty = rst_s.near_empty;

    fq_cfg #(.AW(AW)) u_cfg (
        .clk(wr_clk), .hard_rst(hard_rst), .ft_mode(ft_mode), .cfg_serial(cfg_serial),
        .ofs_preset(ofs_preset), .par_ld(ofs_par_ld), .par_val(ofs_par_val),
        .ser_ld(ofs_ser_ld), .ser_bit(ofs_ser_bit),
        .cfg(cfg), .ae_off(ae_off), .af_off(af_off)
    );

    fq_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
        .clk(wr_clk), .rst(data_rst), .d(rgray), .q(rgray_s)
    );

    fq_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
        .clk(rd_clk), .rst(data_rst), .d(wgray), .q(wgray_s)
    );

    fq_wside #(.AW(AW)) u_wside (
        .clk(wr_clk), .rst(data_rst), .ft(ft), .af_off(af_off), .wr_en(wr_en),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .st(wst), .wr_flag(wr_flag)
    );

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wr_data;
    end

    assign mem_q = mem[raddr];

    fq_rside #(.AW(AW), .DW(DW)) u_rside (
        .clk(rd_clk), .rst(data_rst), .ft(ft), .ae_off(ae_off), .rd_en(rd_en),
        .rewind(rewind), .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr),
        .rgray(rgray), .rd_data(rd_data), .st(rst_s), .rd_flag(rd_flag)
    );
endmodule

// File: tb/dualclk_fifo36_test.sv
`timescale 1ns/1ps
module dualclk_fifo36_test;
    localparam int DEPTH = 2048;
    localparam int AW    = 11;

    logic wr_clk = 0, rd_clk = 0;
    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    logic hard_rst = 1, soft_rst = 0, ft_mode = 0, cfg_serial = 0;
    logic [2:0] ofs_preset = 0;
    logic ofs_par_ld = 0, ofs_ser_ld = 0, ofs_ser_bit = 0;
    logic [AW-1:0] ofs_par_val = 0;
    logic wr_en = 0, rd_en = 0, rewind = 0;
    logic [35:0] wr_data = 0;
    logic wr_flag, near_full, rd_flag, near_empty;
    logic [35:0] rd_data;

    dualclk_fifo36 uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
        .ft_mode(ft_mode), .cfg_serial(cfg_serial), .ofs_preset(ofs_preset),
        .ofs_par_ld(ofs_par_ld), .ofs_par_val(ofs_par_val), .ofs_ser_ld(ofs_ser_ld),
        .ofs_ser_bit(ofs_ser_bit), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
        .near_full(near_full), .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data),
        .rd_flag(rd_flag), .near_empty(near_empty)
    );

    int vectors = 0, miscompares = 0;
    bit tb_ft = 0, done = 0;
    logic [35:0] exp_q[$];
    logic [35:0] hist[$];

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: decide at the rising edge from pre-edge values, compare at the falling edge.
    initial begin
        forever begin
            bit take;
            logic [35:0] pre, got;
            @(posedge rd_clk);
            take = rd_en && !rewind && !hard_rst && !soft_rst && (tb_ft ? rd_flag : !rd_flag);
            pre  = rd_data;
            @(negedge rd_clk);
            if (take) begin
                got = tb_ft ? pre : rd_data;
                if (exp_q.size() == 0) chk("R2 unexpected word", got, 36'hX);
                else                   chk("R2 data order", got, exp_q.pop_front());
            end
        end
    end

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic do_mrst(input bit ft, input bit ser, input logic [2:0] ps);
        @(negedge wr_clk);
        ft_mode = ft; cfg_serial = ser; ofs_preset = ps;
        hard_rst = 1; wr_en = 0; rd_en = 0; tb_ft = ft;
        repeat (4) @(negedge rd_clk);
        exp_q.delete(); hist.delete();
        hard_rst = 0;
        settle();
    endtask

    task automatic do_prst();
        @(negedge wr_clk);
        soft_rst = 1; wr_en = 0; rd_en = 0;
        repeat (4) @(negedge rd_clk);
        exp_q.delete(); hist.delete();
        soft_rst = 0;
        settle();
    endtask

    task automatic write_one(input logic [35:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        if (exp_q.size() < DEPTH) begin
            exp_q.push_back(d);
            hist.push_back(d);
        end
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic write_n(input int n, input logic [35:0] base);
        for (int i = 0; i < n; i++) write_one(base + 36'(i));
    endtask

    task automatic drain();
        int n;
        settle();
        n = exp_q.size();
        @(negedge rd_clk);
        rd_en = 1;
        repeat (n + 3) @(negedge rd_clk);
        rd_en = 0;
        settle();
        chk("R2 all words returned", 36'(exp_q.size()), 36'd0);
    endtask

    initial begin
        logic [35:0] held;
        repeat (3) @(negedge rd_clk);
        // R1: standard mode reset state
        do_mrst(0, 0, 3'd0);
        chk("R1 empty after reset", 36'(rd_flag), 36'd1);
        chk("R1 not full after reset", 36'(wr_flag), 36'd0);
        chk("R1 near_empty after reset", 36'(near_empty), 36'd1);
        chk("R1 near_full clear after reset", 36'(near_full), 36'd0);

        // R2: order through the clock crossing
        write_n(20, 36'h1_0000_0000);
        settle();
        chk("R2 not empty", 36'(rd_flag), 36'd0);
        chk("R6 above offset 8", 36'(near_empty), 36'd0);
        drain();
        chk("R2 empty after drain", 36'(rd_flag), 36'd1);

        // R4: read while empty is dropped
        held = rd_data;
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        chk("R4 rd_data held", rd_data, held);
        chk("R4 still empty", 36'(rd_flag), 36'd1);
        write_one(36'hA_BCDE_F012);
        drain();

        // R3 / R7: fill to full with preset 8
        write_n(2039, 36'h2_0000_0000);
        chk("R7 near_full clear at 9 free", 36'(near_full), 36'd0);
        write_one(36'h2_1111_1111);
        chk("R7 near_full set at 8 free", 36'(near_full), 36'd1);
        write_n(8, 36'h2_2222_0000);
        chk("R3 full flag", 36'(wr_flag), 36'd1);
        write_one(36'hB_AD00_0BAD);
        chk("R3 full after dropped write", 36'(wr_flag), 36'd1);
        drain();
        chk("R3 empty after drain", 36'(rd_flag), 36'd1);

        // R12: rewind replays words
        do_mrst(0, 0, 3'd0);
        write_n(5, 36'h3_0000_0000);
        drain();
        @(negedge rd_clk); rewind = 1; exp_q = hist;
        @(negedge rd_clk); rewind = 0;
        settle();
        chk("R12 data back after rewind", 36'(rd_flag), 36'd0);
        drain();

        // R13: both ports active together
        write_n(4, 36'h4_0000_0000);
        settle();
        fork
            write_n(40, 36'h4_1000_0000);
            begin
                @(negedge rd_clk); rd_en = 1;
                repeat (70) @(negedge rd_clk);
                rd_en = 0;
            end
        join
        drain();
        chk("R13 empty at end", 36'(rd_flag), 36'd1);

        // R8: presets restored by master reset
        do_mrst(0, 0, 3'd1);
        write_n(16, 36'h5_0000_0000);
        settle();
        chk("R8 preset 16 at 16 words", 36'(near_empty), 36'd1);
        write_one(36'h5_FFFF_FFFF);
        settle();
        chk("R8 preset 16 at 17 words", 36'(near_empty), 36'd0);
        drain();
        do_mrst(0, 0, 3'd4);
        write_n(1024, 36'h6_0000_0000);
        settle();
        chk("R8 preset 1024 at 1024 words", 36'(near_empty), 36'd1);
        write_one(36'h6_FFFF_FFFF);
        settle();
        chk("R8 preset 1024 at 1025 words", 36'(near_empty), 36'd0);
        drain();

        // R9: parallel load ae=4, af=5, third value ignored
        do_mrst(0, 0, 3'd3);
        @(negedge wr_clk); ofs_par_ld = 1; ofs_par_val = 11'd4;
        @(negedge wr_clk); ofs_par_val = 11'd5;
        @(negedge wr_clk); ofs_par_val = 11'd9;
        @(negedge wr_clk); ofs_par_ld = 0;
        write_n(4, 36'h7_0000_0000);
        settle();
        chk("R9 ae offset 4 at 4 words", 36'(near_empty), 36'd1);
        write_one(36'h7_0000_0004);
        settle();
        chk("R9 ae offset 4 at 5 words", 36'(near_empty), 36'd0);
        write_n(2037, 36'h7_1000_0000);
        chk("R9 af offset 5 at 6 free", 36'(near_full), 36'd0);
        write_one(36'h7_2000_0000);
        chk("R9 af offset 5 at 5 free", 36'(near_full), 36'd1);
        drain();

        // R10: serial load ae=3, af=100, extra bits ignored
        do_mrst(0, 1, 3'd2);
        for (int i = 0; i < 2 * AW + 4; i++) begin
            logic [AW-1:0] aev, afv;
            aev = 11'd3; afv = 11'd100;
            @(negedge wr_clk);
            ofs_ser_ld = 1;
            ofs_ser_bit = (i < AW) ? aev[i] : (i < 2 * AW) ? afv[i-AW] : 1'b1;
        end
        @(negedge wr_clk); ofs_ser_ld = 0;
        write_n(3, 36'h8_0000_0000);
        settle();
        chk("R10 ae offset 3 at 3 words", 36'(near_empty), 36'd1);
        write_one(36'h8_0000_0003);
        settle();
        chk("R10 ae offset 3 at 4 words", 36'(near_empty), 36'd0);

        // R11: soft reset clears data, keeps offsets
        do_prst();
        chk("R11 empty after soft reset", 36'(rd_flag), 36'd1);
        write_n(3, 36'h9_0000_0000);
        settle();
        chk("R11 offset kept at 3 words", 36'(near_empty), 36'd1);
        write_one(36'h9_0000_0003);
        settle();
        chk("R11 offset kept at 4 words", 36'(near_empty), 36'd0);
        drain();

        // R1 / R5: fall-through mode
        do_mrst(1, 0, 3'd0);
        chk("R1 ft no word after reset", 36'(rd_flag), 36'd0);
        chk("R1 ft room after reset", 36'(wr_flag), 36'd1);
        write_one(36'hC_0FFE_E000);
        settle();
        chk("R5 word ready without read", 36'(rd_flag), 36'd1);
        chk("R5 head word presented", rd_data, 36'hC_0FFE_E000);
        chk("R6 ft count includes presented word", 36'(near_empty), 36'd1);
        drain();
        chk("R5 ready cleared after consume", 36'(rd_flag), 36'd0);
        write_n(2, 36'hD_0000_0000);
        do_prst();
        write_one(36'hD_5555_5555);
        settle();
        chk("R11 ft mode kept after soft reset", 36'(rd_flag), 36'd1);
        chk("R11 ft head after soft reset", rd_data, 36'hD_5555_5555);
        drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_800_000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule